// File: doc/BRIEF.md
# Audio Metadata Register Bank with Block-Aligned Shadowing

This block holds the two 192-bit side-information blocks that a digital audio serial transmitter sends along with the samples. One is the channel-status block and the other is the user-data block. Software writes each block as six 32-bit words over a simple address/data port. The transmitter never reads these staging words. It reads a shadow copy of each block instead.

While transmission is off, the shadow copy follows the staging words in the cycle after each write. While transmission runs, a write only marks its block as pending. The whole block then moves into the shadow at the next block-end strobe from the serializer, so no frame ever carries a half-updated block. Each such load raises a ready flag, which tells software that the next update may be written.

The bank also provides the interrupt set for these flags and for six stream events. This set is made of an enable-write register, a disable-write register, a readable mask and a status register that clears when read. A write-only control word requests a soft reset and a FIFO clear, and these requests are given to neighbouring logic as one-cycle pulses.

Top module: `aud_meta_regbank`

## Requirements
- R1: After reset, all staging words, both shadow blocks, the status flags and the mask are zero, and `irq_o` is low.
- R2: Channel-status word i (0..5) is at address 0x80+4i and user-data word i is at 0x50+4i. Each word reads back as written. Block byte k appears on shadow bits 8k+7:8k, so byte 4i is bits 7:0 of word i and byte 4i+3 is bits 31:24 of word i.
- R3: While `tx_en_i` is low, a written word is visible on its shadow output at the clock edge that accepts the write.
- R4: While `tx_en_i` is high, writes leave the shadow outputs unchanged. At the first edge where `blk_end_i` is high, the whole staged block loads into the shadow. A word written in that same cycle is included in the load.
- R5: A load at block end sets status bit 6 (channel status) or bit 7 (user data). Every edge with `blk_end_i` high sets status bit 13.
- R6: `stream_evt_i[j]` high at an edge sets status bit j, for j = 0..5.
- R7: Writing ones to 0x14 sets mask bits, and writing ones to 0x18 clears them. The mask reads at 0x1C. Only bits 0..7 and 13 can be set.
- R8: A read of 0x20 returns the status flags and clears them at that edge. A flag that is set by an event in the same cycle stays set.
- R9: `irq_o` is high exactly when some status bit is set whose mask bit is also set.
- R10: A write to 0x00 with bit 0 set clears status, mask and pending loads, and pulses `swrst_o` for one cycle after the write. With bit 1 set, it pulses `fifo_clr_o` for one cycle after the write.
- R11: Reads of unmapped addresses return zero. Writes to 0x1C and 0x20 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 8 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational while `bus_rd_i` is high |
| tx_en_i | input | 1 | Transmitter running |
| blk_end_i | input | 1 | One-cycle strobe at the end of each 192-frame block |
| stream_evt_i | input | 6 | Stream event pulses (ready, empty, full, chunk, underrun, overflow) |
| cs_shadow_o | output | 192 | Channel-status block used by the transmitter |
| ud_shadow_o | output | 192 | User-data block used by the transmitter |
| irq_o | output | 1 | Interrupt request |
| swrst_o | output | 1 | Soft reset pulse |
| fifo_clr_o | output | 1 | FIFO clear pulse |

## Verification
Two functions can fall in the same clock edge. The first pair is the clear-on-read of the status register and a new flag-setting event. The second pair is a staging write and the block-end load of the shadow copy. The bench provokes each pair by driving the read (or the write) and the event (or `blk_end_i`) in the same cycle. It then judges the result from the value returned by the read, a second status read, and the shadow word on the port, which must hold the freshly written value.

// File: rtl/aud_meta_pkg.sv
`timescale 1ns/1ps
package aud_meta_pkg;
    localparam int          WORD_W      = 32;
    localparam int          IRQ_W       = 14;
    localparam int          N_STREAM    = 6;
    localparam int          BIT_CS_RDY  = 6;
    localparam int          BIT_UD_RDY  = 7;
    localparam int          BIT_BLK_END = 13;
    localparam logic [13:0] IRQ_IMPL    = 14'h20FF;
    localparam logic [7:0]  A_CTRL      = 8'h00;
    localparam logic [7:0]  A_IEN       = 8'h14;
    localparam logic [7:0]  A_IDIS      = 8'h18;
    localparam logic [7:0]  A_IMSK      = 8'h1C;
    localparam logic [7:0]  A_ISTA      = 8'h20;
    localparam int          UD_BASE     = 'h50;
    localparam int          CS_BASE     = 'h80;
endpackage

// File: rtl/aud_meta_words.sv
`timescale 1ns/1ps
module aud_meta_words #(
    parameter int WORDS  = 6,
    parameter int ADDR_W = 8,
    parameter int BASE   = 'h80
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [31:0]           wdata_i,
    input  logic                  tx_en_i,
    input  logic                  blk_end_i,
    input  logic                  soft_clr_i,
    output logic [WORDS*32-1:0]   shadow_o,
    output logic                  rd_hit_o,
    output logic [31:0]           rd_word_o,
    output logic                  loaded_o
);
    typedef struct packed {
        logic [WORDS-1:0][31:0] stage;
        logic [WORDS-1:0][31:0] shadow;
        logic                   pend;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        loaded_o  = 1'b0;
        rd_hit_o  = 1'b0;
        rd_word_o = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (addr_i == ADDR_W'(BASE + 4 * i)) begin
                rd_hit_o  = 1'b1;
                rd_word_o = st_q.stage[i];
                if (wr_en_i) begin
                    st_d.stage[i] = wdata_i;
                    st_d.pend     = 1'b1;
                end
            end
        end
        if (soft_clr_i) begin
            st_d.pend = 1'b0;
        end else if (!tx_en_i) begin
            // idle transmitter: shadow tracks the staging words directly
            st_d.shadow = st_d.stage;
            st_d.pend   = 1'b0;
        end else if (blk_end_i && st_d.pend) begin
            // running: whole-block swap at the boundary, same-cycle write included
            st_d.shadow = st_d.stage;
            st_d.pend   = 1'b0;
            loaded_o    = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign shadow_o = st_q.shadow;
endmodule

// File: rtl/aud_meta_irq.sv
`timescale 1ns/1ps
module aud_meta_irq #(
    parameter int               IRQ_W = 14,
    parameter logic [IRQ_W-1:0] IMPL  = '1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [IRQ_W-1:0] set_i,
    input  logic             rd_clr_i,
    input  logic             en_wr_i,
    input  logic             dis_wr_i,
    input  logic [IRQ_W-1:0] wbits_i,
    input  logic             soft_clr_i,
    output logic [IRQ_W-1:0] status_o,
    output logic [IRQ_W-1:0] mask_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [IRQ_W-1:0] status;
        logic [IRQ_W-1:0] mask;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_clr_i) st_d.status = '0;
        st_d.status = st_d.status | (set_i & IMPL);   // set beats clear
        if (en_wr_i)  st_d.mask = st_d.mask | (wbits_i & IMPL);
        if (dis_wr_i) st_d.mask = st_d.mask & ~wbits_i;
        if (soft_clr_i) st_d = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign mask_o   = st_q.mask;
    assign irq_o    = |(st_q.status & st_q.mask);
endmodule

// File: rtl/aud_meta_regbank.sv
`timescale 1ns/1ps
module aud_meta_regbank
    import aud_meta_pkg::*;
#(
    parameter int WORDS  = 6,
    parameter int ADDR_W = 8,
    parameter int N_EVT  = 6
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                bus_wr_i,
    input  logic                bus_rd_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [31:0]         bus_wdata_i,
    output logic [31:0]         bus_rdata_o,
    input  logic                tx_en_i,
    input  logic                blk_end_i,
    input  logic [N_EVT-1:0]    stream_evt_i,
    output logic [WORDS*32-1:0] cs_shadow_o,
    output logic [WORDS*32-1:0] ud_shadow_o,
    output logic                irq_o,
    output logic                swrst_o,
    output logic                fifo_clr_o
);
    localparam int BLK_W = WORDS * WORD_W;

    typedef struct packed {
        logic swrst;
        logic fclr;
    } pulse_t;

    pulse_t           pl_d, pl_q;
    logic             ctrl_wr, soft_clr_w, rd_clr;
    logic             cs_hit, ud_hit, cs_loaded, ud_loaded;
    logic [31:0]      cs_word, ud_word;
    logic [IRQ_W-1:0] set_v, status_w, mask_w;

    assign ctrl_wr    = bus_wr_i && (bus_addr_i == ADDR_W'(A_CTRL));
    assign soft_clr_w = ctrl_wr && bus_wdata_i[0];
    assign rd_clr     = bus_rd_i && (bus_addr_i == ADDR_W'(A_ISTA));

    aud_meta_words #(.WORDS(WORDS), .ADDR_W(ADDR_W), .BASE(CS_BASE)) u_cs (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(bus_wr_i), .addr_i(bus_addr_i),
        .wdata_i(bus_wdata_i), .tx_en_i(tx_en_i), .blk_end_i(blk_end_i),
        .soft_clr_i(soft_clr_w), .shadow_o(cs_shadow_o), .rd_hit_o(cs_hit),
        .rd_word_o(cs_word), .loaded_o(cs_loaded)
    );

    aud_meta_words #(.WORDS(WORDS), .ADDR_W(ADDR_W), .BASE(UD_BASE)) u_ud (
        .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(bus_wr_i), .addr_i(bus_addr_i),
        .wdata_i(bus_wdata_i), .tx_en_i(tx_en_i), .blk_end_i(blk_end_i),
        .soft_clr_i(soft_clr_w), .shadow_o(ud_shadow_o), .rd_hit_o(ud_hit),
        .rd_word_o(ud_word), .loaded_o(ud_loaded)
    );

    always_comb begin
        set_v              = '0;
        set_v[N_EVT-1:0]   = stream_evt_i;
        set_v[BIT_CS_RDY]  = cs_loaded;
        set_v[BIT_UD_RDY]  = ud_loaded;
        set_v[BIT_BLK_END] = blk_end_i;
    end

    aud_meta_irq #(.IRQ_W(IRQ_W), .IMPL(IRQ_IMPL)) u_irq (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_v), .rd_clr_i(rd_clr),
        .en_wr_i(bus_wr_i && (bus_addr_i == ADDR_W'(A_IEN))),
        .dis_wr_i(bus_wr_i && (bus_addr_i == ADDR_W'(A_IDIS))),
        .wbits_i(bus_wdata_i[IRQ_W-1:0]), .soft_clr_i(soft_clr_w),
        .status_o(status_w), .mask_o(mask_w), .irq_o(irq_o)
    );

    always_comb begin
        pl_d.swrst = soft_clr_w;
        pl_d.fclr  = ctrl_wr && bus_wdata_i[1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pl_q <= '0;
        else         pl_q <= pl_d;
    end

    assign swrst_o    = pl_q.swrst;
    assign fifo_clr_o = pl_q.fclr;

    always_comb begin
        bus_rdata_o = '0;
        if (bus_rd_i) begin
            if (bus_addr_i == ADDR_W'(A_IMSK))      bus_rdata_o = 32'(mask_w);
            else if (bus_addr_i == ADDR_W'(A_ISTA)) bus_rdata_o = 32'(status_w);
            else if (cs_hit)                        bus_rdata_o = cs_word;
            else if (ud_hit)                        bus_rdata_o = ud_word;
        end
    end

    // shadow width sanity tied to the derived block width
    initial if (BLK_W != WORDS * 32) $display("width mismatch");
endmodule

// File: rtl/aud_meta_regbank_chk.sv
`timescale 1ns/1ps
module aud_meta_regbank_chk
    import aud_meta_pkg::*;
#(
    parameter int WORDS  = 6,
    parameter int ADDR_W = 8,
    parameter int N_EVT  = 6
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                tx_en_i,
    input logic                blk_end_i,
    input logic [N_EVT-1:0]    stream_evt_i,
    input logic                bus_rd_i,
    input logic [ADDR_W-1:0]   bus_addr_i,
    input logic [WORDS*32-1:0] cs_shadow_o,
    input logic [WORDS*32-1:0] ud_shadow_o,
    input logic                irq_o,
    input logic                swrst_o,
    input logic [IRQ_W-1:0]    status_w,
    input logic [IRQ_W-1:0]    mask_w,
    input logic                soft_clr_w
);
    a_r4_cs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_en_i && !blk_end_i) |=> $stable(cs_shadow_o));

    a_r4_ud_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_en_i && !blk_end_i) |=> $stable(ud_shadow_o));

    a_r5_blk_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (blk_end_i && !soft_clr_w) |=> status_w[BIT_BLK_END]);

    a_r6_evt_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stream_evt_i[0] && !soft_clr_w) |=> status_w[0]);

    a_r7_impl_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_w & ~IRQ_IMPL) == '0);

    a_r8_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && bus_addr_i == ADDR_W'(A_ISTA) && stream_evt_i == '0)
        |=> status_w[N_EVT-1:0] == '0);

    a_r9_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_w == '0) |-> !irq_o);

    a_r10_soft_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        soft_clr_w |=> (swrst_o && status_w == '0 && mask_w == '0));
endmodule

bind aud_meta_regbank aud_meta_regbank_chk #(
    .WORDS(WORDS), .ADDR_W(ADDR_W), .N_EVT(N_EVT)
) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_en_i(tx_en_i), .blk_end_i(blk_end_i),
    .stream_evt_i(stream_evt_i), .bus_rd_i(bus_rd_i), .bus_addr_i(bus_addr_i),
    .cs_shadow_o(cs_shadow_o), .ud_shadow_o(ud_shadow_o), .irq_o(irq_o),
    .swrst_o(swrst_o), .status_w(status_w), .mask_w(mask_w),
    .soft_clr_w(soft_clr_w)
);

// File: tb/aud_meta_regbank_test.sv
`timescale 1ns/1ps
module aud_meta_regbank_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr = 1'b0, rd = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0, rdata;
    logic         tx_en = 1'b0, blk_end = 1'b0;
    logic [5:0]   evt = '0;
    logic [191:0] cs_sh, ud_sh;
    logic         irq, swrst, fclr;
    int           checks = 0, errors = 0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    aud_meta_regbank uut (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .tx_en_i(tx_en), .blk_end_i(blk_end), .stream_evt_i(evt),
        .cs_shadow_o(cs_sh), .ud_shadow_o(ud_sh), .irq_o(irq),
        .swrst_o(swrst), .fifo_clr_o(fclr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic pulse_blk();
        @(negedge clk); blk_end = 1'b1;
        @(negedge clk); blk_end = 1'b0;
    endtask

    task automatic pulse_evt(input logic [5:0] e);
        @(negedge clk); evt = e;
        @(negedge clk); evt = '0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq", 32'(irq), 0);
        chk("R1 cs shadow", cs_sh[31:0], 0);
        chk("R1 ud shadow", ud_sh[191:160], 0);
        bus_rd(8'h80, v); chk("R1 cs stage", v, 0);
        bus_rd(8'h20, v); chk("R1 status", v, 0);
        bus_rd(8'h1C, v); chk("R1 mask", v, 0);
    endtask

    task automatic t_idle_write();
        logic [31:0] v;
        tx_en = 1'b0;
        bus_wr(8'h88, 32'hA1B2C3D4);
        chk("R3 cs word2 shadow", cs_sh[95:64], 32'hA1B2C3D4);
        chk("R2 byte8 position", 32'(cs_sh[71:64]), 32'hD4);
        chk("R2 byte11 position", 32'(cs_sh[95:88]), 32'hA1);
        bus_rd(8'h88, v); chk("R2 cs readback", v, 32'hA1B2C3D4);
        bus_wr(8'h64, 32'h0BADF00D);
        chk("R3 ud word5 shadow", ud_sh[191:160], 32'h0BADF00D);
        bus_rd(8'h64, v); chk("R2 ud readback", v, 32'h0BADF00D);
        bus_rd(8'h40, v); chk("R11 unmapped read", v, 0);
    endtask

    task automatic t_run_write();
        logic [31:0] v;
        @(negedge clk); tx_en = 1'b1;
        bus_wr(8'h80, 32'h00000011);
        chk("R4 held while running", cs_sh[31:0], 0);
        pulse_blk();
        chk("R4 loaded at block end", cs_sh[31:0], 32'h11);
        chk("R4 other word intact", cs_sh[95:64], 32'hA1B2C3D4);
        bus_rd(8'h20, v); chk("R5 cs ready and block end", v, 32'h2040);
        bus_rd(8'h20, v); chk("R8 cleared by read", v, 0);
    endtask

    task automatic t_same_cycle();
        logic [31:0] v;
        @(negedge clk); wr = 1'b1; addr = 8'h84; wdata = 32'hCAFE0001; blk_end = 1'b1;
        @(negedge clk); wr = 1'b0; blk_end = 1'b0; wdata = '0;
        chk("R4 same-cycle write loaded", cs_sh[63:32], 32'hCAFE0001);
        bus_rd(8'h20, v); chk("R5 flags after same-cycle load", v, 32'h2040);
        bus_wr(8'h50, 32'h55);
        pulse_blk();
        chk("R4 ud load", ud_sh[31:0], 32'h55);
        bus_rd(8'h20, v); chk("R5 ud ready flag", v, 32'h2080);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        bus_wr(8'h14, 32'hFFFFFFFF);
        bus_rd(8'h1C, v); chk("R7 implemented mask bits", v, 32'h20FF);
        bus_wr(8'h18, 32'h000020F0);
        bus_rd(8'h1C, v); chk("R7 disable clears", v, 32'h000F);
        chk("R9 idle irq low", 32'(irq), 0);
        pulse_evt(6'b010001);
        chk("R9 masked-in event raises irq", 32'(irq), 1);
        bus_rd(8'h20, v); chk("R6 event flags", v, 32'h11);
        chk("R9 irq drops after read", 32'(irq), 0);
        pulse_evt(6'b010000);
        chk("R9 masked-out event quiet", 32'(irq), 0);
        bus_rd(8'h20, v); chk("R6 underrun flag", v, 32'h10);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        pulse_evt(6'b000001);
        @(negedge clk); rd = 1'b1; addr = 8'h20; evt = 6'b000100;
        #1 v = rdata;
        @(negedge clk); rd = 1'b0; evt = '0;
        chk("R8 read returns prior flags", v, 32'h1);
        bus_rd(8'h20, v); chk("R8 same-cycle event survives", v, 32'h4);
    endtask

    task automatic t_write_ro();
        logic [31:0] v;
        bus_wr(8'h20, 32'hFFFF);
        bus_wr(8'h1C, 32'hFFFF);
        bus_rd(8'h1C, v); chk("R11 mask write ignored", v, 32'h000F);
        bus_rd(8'h20, v); chk("R11 status write ignored", v, 0);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        pulse_evt(6'b000010);
        bus_wr(8'h8C, 32'h33333333);
        bus_wr(8'h00, 32'h1);
        chk("R10 swrst pulse", 32'(swrst), 1);
        chk("R10 no fifo clear", 32'(fclr), 0);
        @(negedge clk);
        chk("R10 swrst one cycle", 32'(swrst), 0);
        bus_rd(8'h1C, v); chk("R10 mask cleared", v, 0);
        pulse_blk();
        chk("R10 pending dropped", cs_sh[127:96], 0);
        bus_rd(8'h20, v); chk("R10 only block end after reset", v, 32'h2000);
        bus_wr(8'h00, 32'h2);
        chk("R10 fifo clear pulse", 32'(fclr), 1);
        chk("R10 fifo clear alone", 32'(swrst), 0);
        @(negedge clk);
        chk("R10 fifo clear one cycle", 32'(fclr), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_write();
        t_run_write();
        t_same_cycle();
        t_irq();
        t_collide();
        t_write_ro();
        t_ctrl();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule